// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host with a 16-bit data bus reach a much larger internal space of registers and coefficient RAM. The host sees only eight direct locations, selected by a 3-bit address. To write, the host stages a 32-bit value in two 16-bit write holding registers. It then writes a 16-bit indirect address, and the bridge produces the write strobe itself. To read, the host writes an indirect address to a second location. The bridge fetches the target into a 32-bit read holding register, which the host then reads as two halves.

Each transfer is followed by a fixed busy window of `BUSY_CYC` cycles. During this window the bridge ignores every host write. The indirect space is split into `NCH` channels. Each channel holds `NREG` 16-bit general registers, a 32-bit control register and a coefficient RAM of `RAM_DEPTH` 32-bit words. Bit 31 of a channel's control register is that channel's hold bit. RAM access for a channel is allowed only while its hold bit is set. The hold bits also leave the block, where they suspend each channel's compute engine.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, these are all zero: the holding registers, every indirect target, `busy`, `ch_hold`, and every direct read.
- R2: Direct writes go to the write holding registers: location 0 sets data bits 15:0 and location 1 sets bits 31:16. Direct reads of location 0 and location 1 return bits 15:0 and bits 31:16 of the read holding register.
- R3: A write to direct location 2 takes the data as an indirect address and copies the write holding value into that target. A 16-bit general register takes only bits 15:0.
- R4: A write to direct location 3 takes the data as an indirect address. The read holding register is loaded with the target's value when `busy` falls, and not at any other time. A 16-bit target reads back with bits 31:16 zero.
- R5: A write to location 2 or 3 makes `busy` high for exactly `BUSY_CYC` (4) cycles, starting the cycle after the write. A direct read of location 3 returns `busy` in bit 0 and zeros in the other bits.
- R6: Every host write made while `busy` is high is ignored. This covers holding writes and address writes, and an address write in this window does not extend the busy window.
- R7: The indirect address layout is: bits 15:14 must be 0, bits 13:12 give the channel, and bits 11:0 give the offset. Offset 0x00A is the 32-bit control register, and its bit 31 drives `ch_hold[channel]`. Offsets 0x000 to `NREG`-1 are the 16-bit general registers.
- R8: Offsets 0x100 to 0x100+`RAM_DEPTH`-1 select a channel's RAM. An indirect write there is dropped while that channel's hold bit is clear. An indirect read there returns zero while the hold bit is clear, and the stored word while it is set.
- R9: An indirect address that maps to nothing reads back as zero, and writes to it change nothing. Direct locations 4 to 7, and reads of location 2, return zero. Writes to direct locations 4 to 7 are ignored and do not start `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Direct location select |
| host_wr | input | 1 | Host write enable, one cycle per write |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Combinational read data for `host_addr` |
| busy | output | 1 | High during the post-transfer window |
| ch_hold | output | NCH | Per-channel hold bits (control bit 31) |

## Verification
Some properties are checked on every cycle. The read holding register changes only as `busy` falls. The write holding registers stay still while `busy` is high. An accepted address write always raises `busy`, and the busy counter never goes past its load value. The hold outputs change only on an indirect write strobe.

Other behaviour only the directed scenarios can show: the exact length of the busy window, the data that comes back through the indirect path, and the 16-bit truncation. The same applies to the RAM access being dropped or zeroed while a channel is not held, and to unmapped addresses having no effect.

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge #(
  parameter int NCH       = 4,
  parameter int NREG      = 8,
  parameter int RAM_DEPTH = 16,
  parameter int BUSY_CYC  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      host_addr,
  input  logic            host_wr,
  input  logic [15:0]     host_wdata,
  output logic [15:0]     host_rdata,
  output logic            busy,
  output logic [NCH-1:0]  ch_hold
);
  localparam int CW  = $clog2(BUSY_CYC + 1);
  localparam int GIW = $clog2(NREG);
  localparam int RIW = $clog2(RAM_DEPTH);
  localparam logic [CW-1:0] BUSY_LD  = CW'(BUSY_CYC);
  localparam logic [11:0]   GEN_LIM  = 12'(NREG);
  localparam logic [7:0]    RAM_LIM  = 8'(RAM_DEPTH);
  localparam logic [2:0]    NCH_LIM  = 3'(NCH);

  logic [15:0]   wlo, whi, iaddr;
  logic [31:0]   rhold, rd_val;
  logic          iop_rd;
  logic [CW-1:0] cnt;

  logic [31:0] ctrl [NCH];
  logic [15:0] gen  [NCH][NREG];
  logic [31:0] ram  [NCH][RAM_DEPTH];

  wire [1:0]     ch      = iaddr[13:12];
  wire [11:0]    off     = iaddr[11:0];
  wire [GIW-1:0] gidx    = off[GIW-1:0];
  wire [RIW-1:0] ridx    = off[RIW-1:0];
  wire           mapped  = (iaddr[15:14] == 2'b00) && ({1'b0, ch} < NCH_LIM);
  wire           hit_gen = off < GEN_LIM;
  wire           hit_ctl = off == 12'h00A;
  wire           hit_ram = (off[11:8] == 4'h1) && (off[7:0] < RAM_LIM);
  wire           held    = mapped && ctrl[ch][31];

  assign busy = cnt != '0;
  wire strobe  = cnt == BUSY_LD;
  wire wr_strb = strobe && !iop_rd && mapped;
  wire rd_load = (cnt == CW'(1)) && iop_rd;
  wire accept  = host_wr && !busy;

  for (genvar c = 0; c < NCH; c++) begin : g_hold
    assign ch_hold[c] = ctrl[c][31];
  end

  always_comb begin
    rd_val = '0;
    if (mapped) begin
      if (hit_gen)              rd_val = {16'h0, gen[ch][gidx]};
      else if (hit_ctl)         rd_val = ctrl[ch];
      else if (hit_ram && held) rd_val = ram[ch][ridx];
    end
  end

  always_comb begin
    case (host_addr)
      3'd0:    host_rdata = rhold[15:0];
      3'd1:    host_rdata = rhold[31:16];
      3'd3:    host_rdata = {15'h0, busy};
      default: host_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wlo <= '0; whi <= '0; iaddr <= '0; iop_rd <= 1'b0;
      cnt <= '0; rhold <= '0;
    end else begin
      if (busy) cnt <= cnt - CW'(1);
      if (accept) begin
        case (host_addr)
          3'd0: wlo <= host_wdata;
          3'd1: whi <= host_wdata;
          3'd2: begin iaddr <= host_wdata; iop_rd <= 1'b0; cnt <= BUSY_LD; end
          3'd3: begin iaddr <= host_wdata; iop_rd <= 1'b1; cnt <= BUSY_LD; end
          default: ;
        endcase
      end
      if (rd_load) rhold <= rd_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        ctrl[c] <= '0;
        for (int i = 0; i < NREG; i++)      gen[c][i] <= '0;
        for (int i = 0; i < RAM_DEPTH; i++) ram[c][i] <= '0;
      end
    end else if (wr_strb) begin
      if (hit_gen)              gen[ch][gidx] <= wlo;
      else if (hit_ctl)         ctrl[ch]      <= {whi, wlo};
      else if (hit_ram && held) ram[ch][ridx] <= {whi, wlo};
    end
  end

  p_rhold_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rhold) |-> $fell(busy));
  p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !busy && host_addr[2:1] == 2'b01) |=> busy);
  p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= BUSY_LD);
  p_whold_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({whi, wlo}));
  p_hold_only_on_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strb |=> $stable(ch_hold));
endmodule

// File: tb/sim_ind_reg_bridge.sv
module sim_ind_reg_bridge;
  localparam int BUSY = 4;
  logic clk = 0, rst_n = 0, host_wr = 0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        busy;
  logic [3:0]  ch_hold;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ind_reg_bridge u0 (.clk, .rst_n, .host_addr, .host_wr, .host_wdata,
                     .host_rdata, .busy, .ch_hold);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic hw(logic [2:0] a, logic [15:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    host_addr = a; #1 d = host_rdata;
  endtask

  task automatic iwrite(logic [15:0] ia, logic [31:0] d);
    hw(0, d[15:0]); hw(1, d[31:16]); hw(2, ia);
    repeat (BUSY) @(negedge clk);
  endtask

  task automatic iread(logic [15:0] ia, output logic [31:0] d);
    logic [15:0] lo, hi;
    hw(3, ia);
    repeat (BUSY) @(negedge clk);
    rd(0, lo); rd(1, hi);
    d = {hi, lo};
  endtask

  task automatic t_reset;
    logic [15:0] v; logic [31:0] r;
    chk("R1 busy", busy, 0);
    chk("R1 ch_hold", ch_hold, 0);
    rd(0, v); chk("R1 loc0", v, 0);
    rd(1, v); chk("R1 loc1", v, 0);
    rd(3, v); chk("R1 status", v, 0);
    iread(16'h200A, r); chk("R1 ctrl ch2", r, 0);
    iread(16'h1005, r); chk("R1 gen reg", r, 0);
  endtask

  task automatic t_reg32;
    logic [31:0] r;
    iwrite(16'h200A, 32'h8000_1234);
    chk("R7 ch_hold", ch_hold, 4'b0100);
    iread(16'h200A, r); chk("R3 R4 ctrl readback", r, 32'h8000_1234);
    iwrite(16'h200A, 32'h0000_0001);
    chk("R7 hold cleared", ch_hold, 4'b0000);
  endtask

  task automatic t_reg16;
    logic [31:0] r;
    iwrite(16'h1005, 32'hDEAD_BEEF);
    iread(16'h1005, r); chk("R3 R4 16-bit target", r, 32'h0000_BEEF);
    iread(16'h0005, r); chk("R7 other channel untouched", r, 0);
    iread(16'h1005, r);
    chk("R2 loc0 half", r[15:0], 16'hBEEF);
  endtask

  task automatic t_busy;
    logic [15:0] v;
    hw(2, 16'h1006);
    for (int i = 0; i < BUSY; i++) begin
      chk("R5 busy high", busy, 1);
      rd(3, v); chk("R5 status bit", v, 16'h0001);
      @(negedge clk);
    end
    chk("R5 busy falls", busy, 0);
    rd(3, v); chk("R5 status clear", v, 0);
  endtask

  task automatic t_ignore;
    logic [31:0] r;
    hw(0, 16'hAAAA); hw(1, 16'hBBBB); hw(2, 16'h1006);
    hw(0, 16'h5555); hw(3, 16'h200A); hw(1, 16'h7777);
    @(negedge clk);
    chk("R6 window not extended", busy, 0);
    hw(2, 16'h1007);
    repeat (BUSY) @(negedge clk);
    iread(16'h1007, r); chk("R6 holding kept", r, 32'h0000_AAAA);
  endtask

  task automatic t_ram;
    logic [31:0] r;
    iwrite(16'h0103, 32'h1234_5678);
    iwrite(16'h000A, 32'h8000_0000);
    chk("R8 ch0 held", ch_hold, 4'b0001);
    iread(16'h0103, r); chk("R8 write dropped while unheld", r, 0);
    iwrite(16'h0103, 32'hCAFE_F00D);
    iread(16'h0103, r); chk("R8 ram readback held", r, 32'hCAFE_F00D);
    iwrite(16'h000A, 32'h0);
    iread(16'h0103, r); chk("R8 read zero unheld", r, 0);
    iwrite(16'h000A, 32'h8000_0000);
    iread(16'h0103, r); chk("R8 ram retained", r, 32'hCAFE_F00D);
    iwrite(16'h300A, 32'h8000_0000);
    iwrite(16'h310F, 32'h0F0F_A5A5);
    iread(16'h310F, r); chk("R8 last ram word ch3", r, 32'h0F0F_A5A5);
  endtask

  task automatic t_unmapped;
    logic [31:0] r; logic [15:0] v;
    iwrite(16'hC00A, 32'h8000_0000);
    chk("R9 unmapped write no effect", ch_hold, 4'b1001);
    iread(16'hC00A, r); chk("R9 unmapped reads zero", r, 0);
    iread(16'h2050, r); chk("R9 hole reads zero", r, 0);
    iread(16'h0110, r); chk("R9 past ram end reads zero", r, 0);
    hw(5, 16'hFFFF);
    chk("R9 loc5 write no busy", busy, 0);
    rd(5, v); chk("R9 loc5 reads zero", v, 0);
    rd(2, v); chk("R9 loc2 reads zero", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_reg32; t_reg16; t_busy; t_ignore; t_ram; t_unmapped;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule